// File: doc/BRIEF.md
# Dual-Loop Phase Comparator with Lock Detection

This block compares a reference pulse train against a divided-oscillator pulse train for each of two synthesizer loops (loop 0 and loop 1). For every loop it produces three-state charge-pump controls: drive high, drive low, or neither, which is the high-impedance request. The sense of the drive can be inverted per loop to match the polarity of the external VCO and loop filter. Each comparison window is timed in oscillator clocks. A lock detector then turns those widths into a lock verdict, declaring lock only after three small errors in a row and dropping it at once on a large one.

The two per-loop verdicts are combined into one lock flag. Either loop can be put into power save. A sleeping loop releases its pump and counts as locked in the combined flag. When it wakes, its comparator starts from idle and its lock history is discarded. A single shared output pin carries either the combined lock flag or one of the four raw comparator inputs, chosen by a two-bit monitor select. All inputs are taken to be synchronous to the oscillator clock.

Phase comparator states: PD_IDLE (no window open), PD_LEAD (reference edge seen, waiting for the feedback edge), PD_LAG (feedback edge seen, waiting for the reference edge), PD_BOTH (one-cycle pulse on both drives that closes a window). Transitions: IDLE→LEAD on a reference edge alone; IDLE→LAG on a feedback edge alone; IDLE→BOTH on coincident edges; LEAD→BOTH on the feedback edge; LAG→BOTH on the reference edge; BOTH→IDLE always; any state→IDLE while the loop is in power save. Lock detector states: LK_OPEN (unlocked), LK_GOOD1 and LK_GOOD2 (one and two small errors in a row), LK_HELD (locked). A small error moves OPEN→GOOD1→GOOD2→HELD, and HELD stays HELD. A large error sends any state to OPEN. A medium error sends GOOD1 and GOOD2 back to OPEN. Power save forces OPEN.

Top module: `pfd_lock_monitor`

## Requirements
- R1: When a loop's reference edge arrives first, from the cycle after that edge until the closing edge, the loop drives high if its polarity bit is 1 and drives low if it is 0, with the off output at 0.
- R2: When a loop's feedback edge arrives first, from the cycle after that edge until the closing edge, the loop drives low if its polarity bit is 1 and drives high if it is 0, with the off output at 0.
- R3: With no comparison window open, a loop's drive-high and drive-low are both 0 and its off output is 1. The off output is never 1 while either drive is 1.
- R4: In the cycle after a window closes, including a window where both edges arrive in the same cycle, both drive outputs are 1 for exactly one cycle. The loop then returns to off.
- R5: A window's error width is the number of clocks between the two edges, with 0 for coincident edges. A width of 3 or more makes the loop unlocked from the next cycle.
- R6: A loop becomes locked only after three consecutive windows of width 2 or less. Any larger width restarts the count.
- R7: The combined lock flag is 1 only when each loop is either locked or in power save.
- R8: While a loop's power-on input is 0, its off output is 1 whatever its inputs do, and it counts as locked for the combined flag.
- R9: When a loop leaves power save, its lock history is cleared, so it reads unlocked, and its comparator starts with no window open.
- R10: With the monitor enable at 0, the shared pin shows the combined lock flag. With it at 1, the pin shows loop sel_loop's reference input when sel_fb is 0 and its feedback input when sel_fb is 1, with loop 0 selected by sel_loop = 0.
- R11: After reset, with both loops powered, every loop's off output is 1 and the combined lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Reference oscillator clock; error widths are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 2 | Divided reference pulse, one bit per loop |
| fb_pulse | input | 2 | Divided VCO feedback pulse, one bit per loop |
| pol_pos | input | 2 | Per-loop drive polarity: 1 drives high when the reference leads |
| pwr_on | input | 2 | Per-loop power control: 1 normal, 0 power save |
| mon_en | input | 1 | 0 routes the lock flag to the pin; 1 routes a raw comparator input |
| sel_loop | input | 1 | Monitor loop select: 0 loop 0, 1 loop 1 |
| sel_fb | input | 1 | Monitor source select: 0 reference, 1 feedback |
| drv_hi | output | 2 | Per-loop request to source pump current |
| drv_lo | output | 2 | Per-loop request to sink pump current |
| drv_off | output | 2 | Per-loop request for a high-impedance pump |
| lock_mon_o | output | 1 | Shared lock / monitor pin |

## Verification
The assertions assume that every pulse input is synchronous to the oscillator clock. They also assume that a new edge on a loop does not arrive during that loop's one-cycle closing pulse, since an edge in that cycle is not registered. The stimulus produces one-cycle pulses at falling clock edges and waits several idle cycles after each window closes before the next pair. The sweep covers both loops, both polarities, both arrival orders and widths from 0 to 5. Expected drives and lock flags are computed from the width rules, not taken from the design.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_LEAD = 2'd1,
        PD_LAG  = 2'd2,
        PD_BOTH = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        LK_OPEN  = 2'd0,
        LK_GOOD1 = 2'd1,
        LK_GOOD2 = 2'd2,
        LK_HELD  = 2'd3
    } lk_state_e;

    localparam int NUM_LOOPS = 2;

endpackage

// File: rtl/pfdl_phase_fsm.sv
module pfdl_phase_fsm
    import pfdl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             pol_pos,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             drv_hi,
    output logic             drv_lo,
    output logic             drv_off,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_width
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ref_prev, fb_prev;
    logic             ref_edge, fb_edge;
    logic             pump_up, pump_dn;

    assign ref_edge = ref_in & ~ref_prev;
    assign fb_edge  = fb_in & ~fb_prev;

    // state and width registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PD_IDLE;
            cnt_q    <= '0;
            ref_prev <= 1'b0;
            fb_prev  <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            ref_prev <= ref_in;
            fb_prev  <= fb_in;
        end
    end

    // next state and window measurement
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        meas_valid = 1'b0;
        meas_width = '0;
        if (!pwr_on) begin
            state_d = PD_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PD_IDLE: begin
                    if (ref_edge && fb_edge) begin
                        state_d    = PD_BOTH;
                        meas_valid = 1'b1;
                    end else if (ref_edge) begin
                        state_d = PD_LEAD;
                        cnt_d   = CNT_ONE;
                    end else if (fb_edge) begin
                        state_d = PD_LAG;
                        cnt_d   = CNT_ONE;
                    end
                end
                PD_LEAD: begin
                    if (fb_edge) begin
                        state_d    = PD_BOTH;
                        meas_valid = 1'b1;
                        meas_width = cnt_q;
                        cnt_d      = '0;
                    end else if (cnt_q != CNT_MAX) begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                PD_LAG: begin
                    if (ref_edge) begin
                        state_d    = PD_BOTH;
                        meas_valid = 1'b1;
                        meas_width = cnt_q;
                        cnt_d      = '0;
                    end else if (cnt_q != CNT_MAX) begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                PD_BOTH: begin
                    state_d = PD_IDLE;
                end
                default: state_d = PD_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pump_up = 1'b0;
        pump_dn = 1'b0;
        unique case (state_q)
            PD_IDLE: ;
            PD_LEAD: pump_up = 1'b1;
            PD_LAG:  pump_dn = 1'b1;
            PD_BOTH: begin
                pump_up = 1'b1;
                pump_dn = 1'b1;
            end
            default: ;
        endcase
        if (!pwr_on) begin
            pump_up = 1'b0;
            pump_dn = 1'b0;
        end
        drv_hi  = pol_pos ? pump_up : pump_dn;
        drv_lo  = pol_pos ? pump_dn : pump_up;
        drv_off = ~(pump_up | pump_dn);
    end

    assert_ps_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (state_q == PD_IDLE));

    assert_dead_zone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && meas_valid) |=> (!pwr_on || (drv_hi && drv_lo)));

    assert_off_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |-> (!drv_hi && !drv_lo));

endmodule

// File: rtl/pfdl_lock_fsm.sv
module pfdl_lock_fsm
    import pfdl_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int UNLOCK_W = 3,
    parameter int LOCK_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_width,
    output logic             loop_ok
);

    localparam logic [CNT_W-1:0] UNLOCK_C = CNT_W'(UNLOCK_W);
    localparam logic [CNT_W-1:0] LOCK_C   = CNT_W'(LOCK_W);

    lk_state_e state_q, state_d;
    logic      small_err, large_err;

    assign small_err = meas_valid && (meas_width <= LOCK_C);
    assign large_err = meas_valid && (meas_width >= UNLOCK_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!pwr_on) begin
            state_d = LK_OPEN;
        end else if (large_err) begin
            state_d = LK_OPEN;
        end else if (meas_valid) begin
            unique case (state_q)
                LK_OPEN:  state_d = small_err ? LK_GOOD1 : LK_OPEN;
                LK_GOOD1: state_d = small_err ? LK_GOOD2 : LK_OPEN;
                LK_GOOD2: state_d = small_err ? LK_HELD  : LK_OPEN;
                LK_HELD:  state_d = LK_HELD;
                default:  state_d = LK_OPEN;
            endcase
        end
    end

    always_comb begin
        loop_ok = (!pwr_on) || (state_q == LK_HELD);
    end

    assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && large_err) |=> (state_q != LK_HELD));

    assert_lock_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LK_HELD) |=> ((state_q != LK_HELD) || $past(small_err)));

endmodule

// File: rtl/pfdl_out_mux.sv
module pfdl_out_mux
    import pfdl_pkg::*;
(
    input  logic [NUM_LOOPS-1:0] loop_ok,
    input  logic [NUM_LOOPS-1:0] ref_in,
    input  logic [NUM_LOOPS-1:0] fb_in,
    input  logic                 mon_en,
    input  logic                 sel_loop,
    input  logic                 sel_fb,
    output logic                 pin_o
);

    logic lock_all;
    logic mon_sig;

    always_comb begin
        lock_all = &loop_ok;
        mon_sig  = sel_fb ? fb_in[sel_loop] : ref_in[sel_loop];
        pin_o    = mon_en ? mon_sig : lock_all;
    end

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
    import pfdl_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int UNLOCK_W = 3,
    parameter int LOCK_W   = 2
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [1:0] ref_pulse,
    input  logic [1:0] fb_pulse,
    input  logic [1:0] pol_pos,
    input  logic [1:0] pwr_on,
    input  logic       mon_en,
    input  logic       sel_loop,
    input  logic       sel_fb,
    output logic [1:0] drv_hi,
    output logic [1:0] drv_lo,
    output logic [1:0] drv_off,
    output logic       lock_mon_o
);

    logic [NUM_LOOPS-1:0] loop_ok;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        logic             mv;
        logic [CNT_W-1:0] mw;

        pfdl_phase_fsm #(.CNT_W(CNT_W)) u_phase (
            .clk        (osc_clk),
            .rst_n      (rst_n),
            .pwr_on     (pwr_on[g]),
            .pol_pos    (pol_pos[g]),
            .ref_in     (ref_pulse[g]),
            .fb_in      (fb_pulse[g]),
            .drv_hi     (drv_hi[g]),
            .drv_lo     (drv_lo[g]),
            .drv_off    (drv_off[g]),
            .meas_valid (mv),
            .meas_width (mw)
        );

        pfdl_lock_fsm #(.CNT_W(CNT_W), .UNLOCK_W(UNLOCK_W), .LOCK_W(LOCK_W)) u_lock (
            .clk        (osc_clk),
            .rst_n      (rst_n),
            .pwr_on     (pwr_on[g]),
            .meas_valid (mv),
            .meas_width (mw),
            .loop_ok    (loop_ok[g])
        );
    end

    pfdl_out_mux u_mux (
        .loop_ok  (loop_ok),
        .ref_in   (ref_pulse),
        .fb_in    (fb_pulse),
        .mon_en   (mon_en),
        .sel_loop (sel_loop),
        .sel_fb   (sel_fb),
        .pin_o    (lock_mon_o)
    );

    assert_ps_counts_locked_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!mon_en && (pwr_on == 2'b00)) |-> lock_mon_o);

    assert_ps_released_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!pwr_on[0]) |-> drv_off[0]);

endmodule

// File: tb/pfd_lock_monitor_tb.sv
module pfd_lock_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_r = 2'b00;
    logic [1:0] fb_r = 2'b00;
    logic [1:0] pol_r = 2'b11;
    logic [1:0] pwr_r = 2'b11;
    logic       mon_en_r = 1'b0;
    logic       sel_loop_r = 1'b0;
    logic       sel_fb_r = 1'b0;
    logic [1:0] hi_w, lo_w, off_w;
    logic       pin_w;

    int n_chk = 0;
    int n_bad = 0;
    int lk [2] = '{0, 0};
    bit done = 0;

    always #4 clk = ~clk;

    pfd_lock_monitor dut_i (
        .osc_clk    (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_r),
        .fb_pulse   (fb_r),
        .pol_pos    (pol_r),
        .pwr_on     (pwr_r),
        .mon_en     (mon_en_r),
        .sel_loop   (sel_loop_r),
        .sel_fb     (sel_fb_r),
        .drv_hi     (hi_w),
        .drv_lo     (lo_w),
        .drv_off    (off_w),
        .lock_mon_o (pin_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] drv(input int lp);
        return {hi_w[lp], lo_w[lp], off_w[lp]};
    endfunction

    // one window on loop lp, d clocks between edges
    task automatic send_pair(input int lp, input bit ref_first, input int d);
        logic [2:0] exp_drv;
        if (ref_first) exp_drv = pol_r[lp] ? 3'b100 : 3'b010;
        else           exp_drv = pol_r[lp] ? 3'b010 : 3'b100;
        @(negedge clk);
        if (d == 0) begin
            ref_r[lp] = 1'b1; fb_r[lp] = 1'b1;
        end else if (ref_first) ref_r[lp] = 1'b1;
        else fb_r[lp] = 1'b1;
        @(negedge clk);
        ref_r[lp] = 1'b0; fb_r[lp] = 1'b0;
        if (d == 0) begin
            check("R4 coincident both drives", drv(lp), 3'b110);
        end else begin
            check(ref_first ? "R1 lead drive" : "R2 lag drive", drv(lp), exp_drv);
            for (int j = 1; j < d; j++) begin
                @(negedge clk);
                check(ref_first ? "R1 lead drive held" : "R2 lag drive held", drv(lp), exp_drv);
            end
            if (ref_first) fb_r[lp] = 1'b1; else ref_r[lp] = 1'b1;
            @(negedge clk);
            ref_r[lp] = 1'b0; fb_r[lp] = 1'b0;
            check("R4 closing pulse", drv(lp), 3'b110);
        end
        if (d <= 2) lk[lp] = (lk[lp] < 3) ? lk[lp] + 1 : 3;
        else        lk[lp] = 0;
        @(negedge clk);
        check("R3 idle off", drv(lp), 3'b001);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic exp_ld();
        logic a, b;
        a = !pwr_r[0] || (lk[0] == 3);
        b = !pwr_r[1] || (lk[1] == 3);
        return a & b;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset off", off_w, 2'b11);
        check("R11 reset drives", {hi_w, lo_w}, 4'b0000);
        check("R11 reset lock flag", pin_w, 1'b0);

        // sweep: one loop active, the other asleep
        for (int lp = 0; lp < 2; lp++) begin
            pwr_r = (lp == 0) ? 2'b01 : 2'b10;
            @(negedge clk);
            lk[lp] = 0;
            for (int fc = 0; fc < 2; fc++) begin
                pol_r[lp] = fc[0];
                for (int dir = 0; dir < 2; dir++) begin
                    for (int d = 0; d < 6; d++) begin
                        send_pair(lp, dir[0], d);
                        check("R5 R6 lock after window", pin_w, exp_ld());
                        check("R8 sleeping loop off", off_w[1-lp], 1'b1);
                    end
                    for (int k = 0; k < 3; k++) begin
                        send_pair(lp, dir[0], 2);
                        check("R6 three small windows", pin_w, exp_ld());
                    end
                    send_pair(lp, dir[0], 3);
                    check("R5 width 3 unlocks", pin_w, 1'b0);
                end
            end
        end

        // power save on loop 0
        pol_r = 2'b11;
        pwr_r = 2'b01;
        @(negedge clk);
        for (int k = 0; k < 3; k++) send_pair(0, 1'b1, 1);
        check("R6 locked before sleep", pin_w, 1'b1);
        @(negedge clk); ref_r[0] = 1'b1;
        @(negedge clk); ref_r[0] = 1'b0;
        check("R1 window open", drv(0), 3'b100);
        pwr_r[0] = 1'b0;
        #1;
        check("R8 sleep releases pump", drv(0), 3'b001);
        @(negedge clk);
        check("R8 sleep counts locked", pin_w, 1'b1);
        ref_r[0] = 1'b1;
        @(negedge clk); ref_r[0] = 1'b0;
        @(negedge clk);
        check("R8 pulse ignored asleep", drv(0), 3'b001);
        pwr_r[0] = 1'b1;
        lk[0] = 0;
        #1;
        check("R9 lock cleared on wake", pin_w, 1'b0);
        send_pair(0, 1'b0, 2);
        check("R9 lock count restarts", pin_w, exp_ld());

        // both loops powered
        pwr_r = 2'b11;
        lk[0] = 0; lk[1] = 0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) send_pair(0, 1'b1, 0);
        check("R7 one loop unlocked", pin_w, 1'b0);
        for (int k = 0; k < 3; k++) send_pair(1, 1'b0, 1);
        check("R7 both locked", pin_w, 1'b1);
        send_pair(1, 1'b1, 4);
        check("R7 loop 1 unlocked", pin_w, 1'b0);
        pwr_r[1] = 1'b0;
        #1;
        check("R7 loop 1 asleep", pin_w, 1'b1);

        // monitor select
        pwr_r = 2'b00;
        mon_en_r = 1'b1;
        for (int pat = 0; pat < 2; pat++) begin
            ref_r = pat[0] ? 2'b10 : 2'b01;
            fb_r  = ~ref_r;
            for (int s = 0; s < 4; s++) begin
                sel_loop_r = s[1];
                sel_fb_r   = s[0];
                #1;
                check("R10 monitor select", pin_w,
                      s[0] ? fb_r[s[1]] : ref_r[s[1]]);
            end
        end
        mon_en_r = 1'b0;
        #1;
        check("R10 lock flag routed", pin_w, 1'b1);
        ref_r = 2'b00; fb_r = 2'b00;
        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule